// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Signed Compare

This block is a 32-bit arithmetic logic unit. It is built as a chain of identical one-bit slices. Each slice can invert either operand. It then forms the AND, the OR and a full-adder sum of the two operand bits, and a four-way multiplexer picks one of them as the result bit. Each slice passes its carry to the slice above it. The carry into bit 0 is the b-invert control itself, so inverting b and adding gives a subtract with no separate carry input. Inverting both operands and selecting AND gives NOR.

For the signed compare, the top slice's raw sum bit during a-b is fed back into the compare input of bit 0. The compare inputs of all other bits are tied low. The unit also reports the final carry-out, a signed-overflow flag and a zero flag. All four outputs are registered once, so a result appears one clock after its operands are presented.

Top module: `bsa_alu`

## Requirements
- R1: With op_sel=0 and neither operand inverted, result is a_in AND b_in.
- R2: With op_sel=1 and neither operand inverted, result is a_in OR b_in.
- R3: With op_sel=2 and no inversion, result is the low 32 bits of a_in+b_in, and carry_out is bit 32 of that sum.
- R4: With op_sel=2, inv_b=1 and inv_a=0, result is a_in-b_in modulo 2^32. carry_out is 1 exactly when a_in >= b_in as unsigned values, that is, when there is no borrow.
- R5: With op_sel=0 and both inv_a=1 and inv_b=1, result is NOR(a_in, b_in).
- R6: With op_sel=3, inv_b=1 and inv_a=0, result bits 31..1 are 0. Result bit 0 equals bit 31 of the wrapped difference a_in-b_in.
- R7: ovf is 1 exactly when the carry into bit 31 differs from the carry out of bit 31. For add and subtract this is signed two's-complement overflow.
- R8: zero is 1 exactly when all 32 bits of result are 0.
- R9: All outputs change only on a rising clk edge and reflect the inputs present at that edge. While rst is high at an edge, result becomes 0, carry_out and ovf become 0, and zero becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 32 | Operand a |
| b_in | input | 32 | Operand b |
| inv_a | input | 1 | Invert operand a before the slice logic |
| inv_b | input | 1 | Invert operand b; also the carry into bit 0 |
| op_sel | input | 2 | Result select: 0 AND, 1 OR, 2 sum, 3 compare |
| result | output | 32 | Registered result |
| carry_out | output | 1 | Registered carry out of bit 31 |
| ovf | output | 1 | Registered signed overflow (carry into bit 31 XOR carry out of bit 31) |
| zero | output | 1 | Registered flag, set when result is all zero |

## Verification
Two functions can act in the same cycle. The adder's carry-out and the zero flag do so when an add wraps exactly to zero, as in all-ones plus one or a value minus itself. The compare output and the overflow flag do so when a-b crosses the signed range, for example the most negative value minus one. In that case the compare bit shows the wrapped sign and ovf is high together. The bench drives these operands as directed corners and also reaches them through random operands. It checks each flag against a model built from the raw operand sum.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_SUM  = 2'd2,
    OP_LESS = 2'd3
  } bsa_op_e;
endpackage

// File: rtl/bsa_slice.sv
module bsa_slice
  import bsa_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       inv_a,
  input  logic       inv_b,
  input  logic       carry_in,
  input  logic       less_in,
  input  logic [1:0] op_sel,
  output logic       res_bit,
  output logic       carry_o,
  output logic       sum_o
);
  logic a_eff, b_eff, and_t, or_t;

  always_comb begin
    a_eff   = inv_a ? ~a_bit : a_bit;
    b_eff   = inv_b ? ~b_bit : b_bit;
    and_t   = a_eff & b_eff;
    or_t    = a_eff | b_eff;
    sum_o   = a_eff ^ b_eff ^ carry_in;
    carry_o = (a_eff & carry_in) | (b_eff & carry_in) | (a_eff & b_eff);
    case (bsa_op_e'(op_sel))
      OP_AND:  res_bit = and_t;
      OP_OR:   res_bit = or_t;
      OP_SUM:  res_bit = sum_o;
      default: res_bit = less_in;
    endcase
  end
endmodule

// File: rtl/bsa_chain.sv
module bsa_chain #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic [1:0]   op_sel,
  output logic [W-1:0] res,
  output logic         carry_out,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W:0]   carry;
  logic [W-1:0] sums;
  logic [W-1:0] less;

  assign carry[0] = inv_b;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_slice
      if (i == 0) begin : g_lsb
        assign less[i] = sums[MSB];
      end else begin : g_upper
        assign less[i] = 1'b0;
      end
      bsa_slice u_slice (
        .a_bit    (a_in[i]),
        .b_bit    (b_in[i]),
        .inv_a    (inv_a),
        .inv_b    (inv_b),
        .carry_in (carry[i]),
        .less_in  (less[i]),
        .op_sel   (op_sel),
        .res_bit  (res[i]),
        .carry_o  (carry[i+1]),
        .sum_o    (sums[i])
      );
    end
  endgenerate

  assign carry_out = carry[W];
  assign ovf       = carry[MSB] ^ carry[W];
endmodule

// File: rtl/bsa_alu.sv
module bsa_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic [1:0]   op_sel,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         ovf,
  output logic         zero
);
  logic [W-1:0] res_c;
  logic         carry_c, ovf_c;

  bsa_chain #(.W(W)) u_chain (
    .a_in      (a_in),
    .b_in      (b_in),
    .inv_a     (inv_a),
    .inv_b     (inv_b),
    .op_sel    (op_sel),
    .res       (res_c),
    .carry_out (carry_c),
    .ovf       (ovf_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      ovf       <= 1'b0;
      zero      <= 1'b1;
    end else begin
      result    <= res_c;
      carry_out <= carry_c;
      ovf       <= ovf_c;
      zero      <= (res_c == '0);
    end
  end
endmodule

// File: rtl/bsa_alu_chk.sv
module bsa_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         inv_a,
  input logic         inv_b,
  input logic [1:0]   op_sel,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         ovf,
  input logic         zero
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    armed |-> (zero == (result == '0))); // R8

  AST_AND_PATH: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) == 2'd0 && !$past(inv_a) && !$past(inv_b))
      |-> result == ($past(a_in) & $past(b_in))); // R1

  AST_OR_PATH: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) == 2'd1 && !$past(inv_a) && !$past(inv_b))
      |-> result == ($past(a_in) | $past(b_in))); // R2

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) == 2'd2 && !$past(inv_a) && !$past(inv_b))
      |-> {carry_out, result} == ({1'b0, $past(a_in)} + {1'b0, $past(b_in)})); // R3

  AST_LESS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) == 2'd3) |-> result[W-1:1] == '0); // R6

  AST_ADD_OVF: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_sel) == 2'd2 && !$past(inv_a) && !$past(inv_b))
      |-> ovf == (($past(a_in[W-1]) == $past(b_in[W-1])) &&
                  (result[W-1] != $past(a_in[W-1])))); // R7
endmodule

bind bsa_alu bsa_alu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .a_in      (a_in),
  .b_in      (b_in),
  .inv_a     (inv_a),
  .inv_b     (inv_b),
  .op_sel    (op_sel),
  .result    (result),
  .carry_out (carry_out),
  .ovf       (ovf),
  .zero      (zero)
);

// File: tb/bsa_alu_tb.sv
`timescale 1ns/1ps
module bsa_alu_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         inv_a = 1'b0, inv_b = 1'b0;
  logic [1:0]   op_sel = 2'd0;
  logic [W-1:0] result;
  logic         carry_out, ovf, zero;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bsa_alu #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .inv_a(inv_a),
    .inv_b(inv_b), .op_sel(op_sel), .result(result),
    .carry_out(carry_out), .ovf(ovf), .zero(zero)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic ia, input logic ib, input logic [1:0] op);
    if (op == 2'd0 && !ia && !ib) return "R1";
    if (op == 2'd1 && !ia && !ib) return "R2";
    if (op == 2'd2 && !ia && !ib) return "R3";
    if (op == 2'd2 && !ia && ib)  return "R4";
    if (op == 2'd0 && ia && ib)   return "R5";
    if (op == 2'd3 && !ia && ib)  return "R6";
    return "R7";
  endfunction

  // Reference from the requirements: operand inversion, carry in = inv_b.
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic ia, input logic ib, input logic [1:0] op);
    logic [W-1:0] ae, be, exp_r;
    logic [W:0]   s;
    logic         exp_ovf;
    ae = ia ? ~a : a;
    be = ib ? ~b : b;
    s  = {1'b0, ae} + {1'b0, be} + {{W{1'b0}}, ib};
    exp_ovf = (ae[W-1] == be[W-1]) && (s[W-1] != ae[W-1]);
    case (op)
      2'd0:    exp_r = ae & be;
      2'd1:    exp_r = ae | be;
      2'd2:    exp_r = s[W-1:0];
      default: exp_r = {{(W-1){1'b0}}, s[W-1]};
    endcase
    @(negedge clk);
    a_in = a; b_in = b; inv_a = ia; inv_b = ib; op_sel = op;
    @(posedge clk); #1;
    check(op_tag(ia, ib, op), result, exp_r);
    check("R3/R4 carry", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, s[W]});
    check("R7 ovf", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, exp_ovf});
    check("R8 zero", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, exp_r == '0});
  endtask

  task automatic all_ops(input logic [W-1:0] a, input logic [W-1:0] b);
    run(a, b, 1'b0, 1'b0, 2'd0);
    run(a, b, 1'b0, 1'b0, 2'd1);
    run(a, b, 1'b0, 1'b0, 2'd2);
    run(a, b, 1'b0, 1'b1, 2'd2);
    run(a, b, 1'b1, 1'b1, 2'd0);
    run(a, b, 1'b0, 1'b1, 2'd3);
  endtask

  initial begin
    logic [W-1:0] corners [4];
    logic [W-1:0] held;
    void'($urandom(32'd1234));
    corners[0] = '0;
    corners[1] = '1;
    corners[2] = {1'b1, {(W-1){1'b0}}};
    corners[3] = {1'b0, {(W-1){1'b1}}};

    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9 reset result", result, '0);
    check("R9 reset flags", {{(W-3){1'b0}}, carry_out, ovf, zero}, {{(W-3){1'b0}}, 3'b001});
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        all_ops(corners[i], corners[j]);

    // Carry-out and zero together; compare with overflow
    run('1, 32'd1, 1'b0, 1'b0, 2'd2);
    run(32'h1234_5678, 32'h1234_5678, 1'b0, 1'b1, 2'd2);
    run(32'h8000_0000, 32'd1, 1'b0, 1'b1, 2'd3);
    run(32'd5, 32'd7, 1'b0, 1'b1, 2'd3);
    run(32'd7, 32'd5, 1'b0, 1'b1, 2'd3);

    // R9: output holds between edges
    run(32'h0F0F_0F0F, 32'h00FF_00FF, 1'b0, 1'b0, 2'd0);
    held = result;
    @(negedge clk);
    a_in = 32'hFFFF_FFFF; b_in = 32'hFFFF_FFFF; op_sel = 2'd1;
    #1;
    check("R9 hold", result, held);
    @(posedge clk); #1;
    check("R9 update", result, 32'hFFFF_FFFF);

    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] ra, rb;
      int sel;
      ra = $urandom(); rb = $urandom();
      if (k % 7 == 0) ra = rb;
      sel = $urandom_range(0, 5);
      case (sel)
        0: run(ra, rb, 1'b0, 1'b0, 2'd0);
        1: run(ra, rb, 1'b0, 1'b0, 2'd1);
        2: run(ra, rb, 1'b0, 1'b0, 2'd2);
        3: run(ra, rb, 1'b0, 1'b1, 2'd2);
        4: run(ra, rb, 1'b1, 1'b1, 2'd0);
        default: run(ra, rb, 1'b0, 1'b1, 2'd3);
      endcase
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule